// File: doc/BRIEF.md
# Differential Oscillator Edge-Count Quantizer

This block is the digital back end of an oscillator-based converter. Two voltage-controlled oscillators, one driven by the positive input and one by the negative input, deliver square waves whose frequencies follow the analog signal. During every sampling period the block counts the rising edges of each oscillator. The difference between the two counts is the signed, differential conversion result.

All logic runs on a fast reference clock. The oscillator outputs and the slow sampling clock arrive asynchronously and pass through identical synchronizer chains. A rising edge of the sampling clock ends a period. The edge counters run only inside a counting window. The window opens on the first reference cycle after a sampling edge and closes a fixed number of reference cycles before the next nominal edge, so each count is frozen before it is taken.

Each counter has two capture registers: one loaded while the count is frozen, one loaded at the sampling edge. A chooser takes the frozen value when the window closed in time, and the value at the edge when the sampling edge came early. A parameter selects a multi-phase variant, in which the counts of all phases of one side are added together. For a 10-bit result per counter, the oscillator must run at least 1024 times faster than the sampling clock. The same logic serves a single channel at a low sample rate or several multiplexed channels at a proportionally higher rate, through `SAMPLE_CYCLES`.

Top module: `osc_diff_quantizer`

## Requirements
- R1: While reset is asserted, and until the first sampling edge after reset has produced a result, `result` is 0 and `result_valid` is 0.
- R2: Each counter counts the rising edges of its oscillator seen in a window of `SAMPLE_CYCLES - GUARD_CYCLES` reference cycles. The window starts on the first reference cycle after the detected sampling edge.
- R3: During the last `GUARD_CYCLES` reference cycles before the nominal sampling edge, the counters do not change.
- R4: At each detected sampling edge every counter is cleared, so the next period is counted from zero.
- R5: A counter that reaches `2**COUNT_W - 1` stays at that value until it is cleared; it never wraps.
- R6: `result` is the positive-side count minus the negative-side count, in two's complement, `COUNT_W + clog2(PHASES) + 1` bits wide.
- R7: With `PHASES` greater than 1, the count of each side is the sum of the saturated counts of all its phases.
- R8: `result_valid` is a one-cycle pulse two reference cycles after each detected sampling edge. `result` changes only in a cycle where `result_valid` is high.
- R9: If the sampling edge arrives before the window closes, the result uses the count reached at that edge. Otherwise it uses the count frozen when the window closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_pos | input | PHASES | Phase outputs of the positive-input oscillator |
| osc_neg | input | PHASES | Phase outputs of the negative-input oscillator |
| smp_clk | input | 1 | Slow sampling clock; its rising edge ends a period |
| result | output | COUNT_W+clog2(PHASES)+1 | Signed differential conversion result |
| result_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The hardest case to reach from the ports is the late capture path. Its choice is taken only when a sampling edge arrives while the counting window is still open, which never happens at the nominal rate. The stimulus shortens the sampling clock period below the window length for a few periods. It then checks that the result tracks the edges counted up to the early edge and not a stale frozen value. It then restores the nominal period to show that the frozen path is used again. The frozen window itself is shown by oscillator periods that divide the window exactly: a count taken over the full period would come out several codes higher.

// File: rtl/dq_pkg.sv
package dq_pkg;

  // width of the per-side sum of PHASES counters of cw bits each
  function automatic int sum_width(input int cw, input int phases);
    return cw + $clog2(phases);
  endfunction

endpackage

// File: rtl/dq_sync_edge.sv
module dq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic [STAGES-1:0] chain_q, chain_d;
  logic              last_q, last_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
    last_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= last_d;
    end
  end

  assign rise = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/dq_window.sv
module dq_window #(
  parameter int SAMPLE_CYCLES = 10000,
  parameter int GUARD_CYCLES  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic cnt_en,
  output logic frozen
);

  localparam int OPEN_CYCLES = SAMPLE_CYCLES - GUARD_CYCLES;
  localparam int EW          = $clog2(OPEN_CYCLES + 1);
  localparam logic [EW-1:0] OPEN_V = EW'(OPEN_CYCLES);

  logic [EW-1:0] elapsed_q, elapsed_d;

  always_comb begin
    elapsed_d = elapsed_q;
    if (tick)
      elapsed_d = '0;
    else if (elapsed_q < OPEN_V)
      elapsed_d = elapsed_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elapsed_q <= '0;
    else        elapsed_q <= elapsed_d;
  end

  assign cnt_en = (elapsed_q < OPEN_V);
  assign frozen = (elapsed_q == OPEN_V);

endmodule

// File: rtl/dq_phase_counter.sv
module dq_phase_counter #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          cnt_en,
  input  logic          clr,
  input  logic          frozen,
  output logic [CW-1:0] live,
  output logic [CW-1:0] pick
);

  localparam logic [CW-1:0] MAX_V = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] early_q, early_d;
  logic [CW-1:0] late_q, late_d;
  logic          sel_q, sel_d;

  always_comb begin
    cnt_d   = cnt_q;
    early_d = early_q;
    late_d  = late_q;
    sel_d   = sel_q;
    if (clr)
      cnt_d = '0;
    else if (cnt_en && rise && (cnt_q != MAX_V))
      cnt_d = cnt_q + 1'b1;
    if (frozen)
      early_d = cnt_q;
    if (clr) begin
      late_d = cnt_q;
      sel_d  = frozen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      early_q <= '0;
      late_q  <= '0;
      sel_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      early_q <= early_d;
      late_q  <= late_d;
      sel_q   <= sel_d;
    end
  end

  assign live = cnt_q;
  assign pick = sel_q ? early_q : late_q;

endmodule

// File: rtl/osc_diff_quantizer.sv
module osc_diff_quantizer #(
  parameter int COUNT_W       = 11,
  parameter int PHASES        = 1,
  parameter int SAMPLE_CYCLES = 10000,
  parameter int GUARD_CYCLES  = 64,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [PHASES-1:0]                     osc_pos,
  input  logic [PHASES-1:0]                     osc_neg,
  input  logic                                  smp_clk,
  output logic signed [COUNT_W+$clog2(PHASES):0] result,
  output logic                                  result_valid
);

  localparam int SW = dq_pkg::sum_width(COUNT_W, PHASES);
  localparam int RW = SW + 1;

  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  logic smp_tick, cnt_en, frozen;

  dq_sync_edge #(.STAGES(SYNC_STAGES)) u_smp_sync (
    .clk(clk), .rst_n(rst_q), .din(smp_clk), .rise(smp_tick)
  );

  dq_window #(.SAMPLE_CYCLES(SAMPLE_CYCLES), .GUARD_CYCLES(GUARD_CYCLES)) u_window (
    .clk(clk), .rst_n(rst_q), .tick(smp_tick), .cnt_en(cnt_en), .frozen(frozen)
  );

  logic [PHASES-1:0]              rise_p, rise_n;
  logic [PHASES-1:0][COUNT_W-1:0] cnt_p, cnt_n, pick_p, pick_n;

  for (genvar g = 0; g < PHASES; g++) begin : g_phase
    dq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_p (
      .clk(clk), .rst_n(rst_q), .din(osc_pos[g]), .rise(rise_p[g])
    );
    dq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_n (
      .clk(clk), .rst_n(rst_q), .din(osc_neg[g]), .rise(rise_n[g])
    );
    dq_phase_counter #(.CW(COUNT_W)) u_cnt_p (
      .clk(clk), .rst_n(rst_q), .rise(rise_p[g]), .cnt_en(cnt_en), .clr(smp_tick),
      .frozen(frozen), .live(cnt_p[g]), .pick(pick_p[g])
    );
    dq_phase_counter #(.CW(COUNT_W)) u_cnt_n (
      .clk(clk), .rst_n(rst_q), .rise(rise_n[g]), .cnt_en(cnt_en), .clr(smp_tick),
      .frozen(frozen), .live(cnt_n[g]), .pick(pick_n[g])
    );
  end

  logic [SW-1:0] sum_p, sum_n;

  always_comb begin
    sum_p = '0;
    sum_n = '0;
    for (int i = 0; i < PHASES; i++) begin
      sum_p = sum_p + SW'(pick_p[i]);
      sum_n = sum_n + SW'(pick_n[i]);
    end
  end

  logic                 tick_d_q;
  logic signed [RW-1:0] res_q, res_d;
  logic                 vld_q, vld_d;

  always_comb begin
    res_d = res_q;
    vld_d = tick_d_q;
    if (tick_d_q)
      res_d = $signed({1'b0, sum_p}) - $signed({1'b0, sum_n});
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      tick_d_q <= 1'b0;
      res_q    <= '0;
      vld_q    <= 1'b0;
    end else begin
      tick_d_q <= smp_tick;
      res_q    <= res_d;
      vld_q    <= vld_d;
    end
  end

  assign result       = res_q;
  assign result_valid = vld_q;

endmodule

// File: rtl/osc_diff_quantizer_chk.sv
module osc_diff_quantizer_chk #(
  parameter int CW = 11,
  parameter int RW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          cnt_en,
  input logic [CW-1:0] cnt0,
  input logic [RW-1:0] result,
  input logic          valid
);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  a_r8_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(tick, 2));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> valid);

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt0 == '0));

  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !tick) |=> $stable(cnt0));

  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (cnt0 >= $past(cnt0)));

endmodule

bind osc_diff_quantizer osc_diff_quantizer_chk #(
  .CW(COUNT_W), .RW(COUNT_W + $clog2(PHASES) + 1)
) u_chk (
  .clk(clk), .rst_n(rst_q), .tick(smp_tick), .cnt_en(cnt_en),
  .cnt0(cnt_p[0]), .result(result), .valid(result_valid)
);

// File: tb/osc_diff_quantizer_test.sv
module osc_diff_quantizer_test;

  localparam int CW     = 10;
  localparam int PH     = 2;
  localparam int SMP    = 2432;
  localparam int GUARD  = 32;
  localparam int OPEN   = SMP - GUARD;   // 2400 cycles counting window
  localparam int RW     = CW + 1 + 1;
  localparam int MAXC   = (1 << CW) - 1;
  localparam int NVEC   = 13;

  // each entry: {half period pos, half period neg, second phase active}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd5,  8'd0,  8'd0},   // 240 : window frozen before edge
    {8'd1,  8'd0,  8'd0},   // saturates at 1023
    {8'd0,  8'd1,  8'd0},   // -1023
    {8'd5,  8'd5,  8'd0},   // 0
    {8'd2,  8'd3,  8'd0},   // 200
    {8'd3,  8'd10, 8'd0},   // 280
    {8'd10, 8'd3,  8'd0},   // -280
    {8'd0,  8'd0,  8'd0},   // 0
    {8'd50, 8'd60, 8'd0},   // 4
    {8'd2,  8'd0,  8'd1},   // 1200 : two phases
    {8'd1,  8'd0,  8'd1},   // 2046 : two saturated phases
    {8'd3,  8'd5,  8'd1},   // 320
    {8'd25, 8'd4,  8'd1}    // -504
  };

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [PH-1:0]        osc_pos, osc_neg;
  logic                 smp_clk;
  logic signed [RW-1:0] result;
  logic                 result_valid;

  int n_checks = 0;
  int n_fail   = 0;
  int half_p = 0, half_n = 0, cp = 0, cn = 0;
  bit dual = 1'b0;
  int smp_per = SMP, sc = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  osc_diff_quantizer #(
    .COUNT_W(CW), .PHASES(PH), .SAMPLE_CYCLES(SMP),
    .GUARD_CYCLES(GUARD), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .osc_pos(osc_pos), .osc_neg(osc_neg),
    .smp_clk(smp_clk), .result(result), .result_valid(result_valid)
  );

  initial begin
    osc_pos = '0;
    osc_neg = '0;
    smp_clk = 1'b0;
  end

  // oscillator and sampling clock models, all changes away from the active edge
  always @(negedge clk) begin
    osc_pos[1] = dual ? osc_pos[0] : 1'b0;
    osc_neg[1] = dual ? osc_neg[0] : 1'b0;
    if (half_p == 0) begin osc_pos[0] = 1'b0; cp = 0; end
    else if (cp >= half_p - 1) begin osc_pos[0] = ~osc_pos[0]; cp = 0; end
    else cp++;
    if (half_n == 0) begin osc_neg[0] = 1'b0; cn = 0; end
    else if (cn >= half_n - 1) begin osc_neg[0] = ~osc_neg[0]; cn = 0; end
    else cn++;
    if (sc >= smp_per - 1) sc = 0; else sc++;
    smp_clk = (sc >= smp_per / 2);
  end

  function automatic int side_cnt(input int h, input int win);
    int c;
    if (h == 0) return 0;
    c = win / (2 * h);
    if (c > MAXC) c = MAXC;
    return c;
  endfunction

  task automatic check(input string req, input int act, input int exp, input int tol);
    n_checks++;
    if (act > exp + tol || act < exp - tol) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_valid();
    @(negedge clk);
    while (!result_valid) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    int exp;
    int held;
    rst_n = 1'b0;
    repeat (10) @(negedge clk);
    check("R1 valid in reset", int'(result_valid), 0, 0);
    check("R1 result in reset", int'(result), 0, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R1 result before first edge", int'(result), 0, 0);
    check("R1 valid before first edge", int'(result_valid), 0, 0);
    wait_valid();

    // table walk: R2 window count, R5 saturation, R6 difference, R7 phase sum
    for (int v = 0; v < NVEC; v++) begin
      half_p = int'(VEC[v][23:16]);
      half_n = int'(VEC[v][15:8]);
      dual   = VEC[v][0];
      exp = (side_cnt(half_p, OPEN) - side_cnt(half_n, OPEN)) * (dual ? 2 : 1);
      wait_valid();
      wait_valid();
      check($sformatf("R2 R5 R6 R7 vector %0d", v), int'(result), exp, 1);
      @(negedge clk);
      check("R8 valid one cycle", int'(result_valid), 0, 0);
    end

    // R8 hold: result unchanged between strobes
    held = int'(result);
    repeat (SMP / 2) @(negedge clk);
    check("R8 result held", int'(result), held, 0);

    // R9 / R4: early sampling edge, count up to edge, restarted from zero
    half_p = 5; half_n = 0; dual = 1'b0;
    smp_per = 1500;
    wait_valid();
    wait_valid();
    wait_valid();
    check("R9 R4 early edge late capture", int'(result), 150, 1);
    wait_valid();
    check("R9 R4 early edge repeat", int'(result), 150, 1);

    // R3 / R9: nominal period again, frozen value (full period would give 243)
    smp_per = SMP;
    wait_valid();
    wait_valid();
    wait_valid();
    check("R3 R9 frozen capture", int'(result), side_cnt(5, OPEN), 1);

    // R1: reset in mid run clears the output
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 result after mid reset", int'(result), 0, 0);
    check("R1 valid after mid reset", int'(result_valid), 0, 0);
    rst_n = 1'b1;
    half_p = 0; half_n = 4;
    wait_valid();
    wait_valid();
    check("R6 negative after reset", int'(result), -side_cnt(4, OPEN), 1);

    finish_run();
  end

endmodule